// File: doc/BRIEF.md
# Two-Clock First-Word-Fall-Through FIFO

This block carries data words in one direction between a write clock and an unrelated read clock. Words written on the write side are stored in a small memory. The first stored word moves by itself into an output register on the read side, and a ready flag marks that register as holding valid data. A consumer therefore sees the head word before it asks for it. It takes the word by raising its read enable while the flag is high, and the next word, if one is there, replaces it on that same edge.

Each side has its own flow-control flag. On the write side a flag shows that there is room for another word. On the read side a flag shows that the output register is valid. Two optional level flags, each set by a fixed parameter offset, warn when the block is nearly full or nearly empty. Read and write positions cross between the clock domains as Gray-coded pointers, through a parameterized chain of at least two flip-flops. Each domain works against a delayed view of the other side. The flags can therefore hold back for a few cycles, but they never claim space or data that does not exist.

Top module: `xclk_fwft_fifo`

## Requirements
- R1: While its domain's synchronous reset is high, and on the first sample after it is released, `in_ready` is 1 and `almost_full` is 0 on the write side, and `out_ready` is 0 and `almost_empty` is 1 on the read side.
- R2: Words come out in the order in which they were accepted, with no loss and no duplication, for any mix of write and read duty cycles. Total capacity is 2**ADDR_W stored words plus one word in the output register.
- R3: When `out_ready` is 0 and a word is written, that word appears on `rd_data` and `out_ready` rises without any read request, within SYNC_STAGES+4 read-clock cycles of the write edge.
- R4: While `out_ready` is 1 and `rd_en` is 0, both `out_ready` and `rd_data` hold their values.
- R5: A write presented while `in_ready` is 0 is ignored: it neither stores a word nor overwrites a stored word.
- R6: A read presented while `out_ready` is 0 is ignored: it consumes no word and leaves `rd_data` unchanged.
- R7: A read that takes the last available word drives `out_ready` to 0, and `rd_data` then keeps the value of that last word.
- R8: The flags are pessimistic. The write side never counts more than 2**ADDR_W stored words, and `out_ready` never rises while the read side sees no stored word.
- R9: With ALMOST_EN=1, `almost_full` is 1 when the write side's count of stored words is at least 2**ADDR_W - AF_OFFSET, and 0 otherwise. This count covers the memory only.
- R10: With ALMOST_EN=1, `almost_empty` is 1 when the read side's count of words, stored words plus one for a valid output register, is at most AE_OFFSET, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| wrst | input | 1 | Synchronous reset of the write side, active high |
| wr_en | input | 1 | Write request, accepted when `in_ready` is 1 |
| wr_data | input | DATA_W | Word to store |
| in_ready | output | 1 | Space available (write clock) |
| almost_full | output | 1 | Fill level at or above the full threshold (write clock) |
| rclk | input | 1 | Read-side clock |
| rrst | input | 1 | Synchronous reset of the read side, active high |
| rd_en | input | 1 | Read request, takes the word when `out_ready` is 1 |
| rd_data | output | DATA_W | Output register holding the head word |
| out_ready | output | 1 | `rd_data` holds a valid word (read clock) |
| almost_empty | output | 1 | Word count at or below the empty threshold (read clock) |

## Verification
The bench sweeps a grid of write and read duty cycles, from both sides streaming to one side running three times slower than the other. A scoreboard checks every delivered word against an arithmetic pattern, so a dropped, repeated or reordered word shows up under back-pressure as well as under starvation. A saturating write burst with the reader idle counts the accepted words. This separates a correct capacity of depth plus one from an overwrite or an early stop. The bench also probes the empty boundary: reads issued into an empty block, a single word that must fall through on its own, and a hold with the read enable low. These cases separate the automatic load from a load that waits for a read, and they catch a dropped-valid bug.

// File: rtl/xfifo_pkg.sv
package xfifo_pkg;

   localparam int MAX_ADDR_W = 12;

   function automatic logic [31:0] bin_to_gray(logic [31:0] b);
      return b ^ (b >> 1);
   endfunction

   function automatic logic [31:0] gray_to_bin(logic [31:0] g);
      logic [31:0] b;
      b[31] = g[31];
      for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
      return b;
   endfunction

endpackage

// File: rtl/xfifo_sync.sv
module xfifo_sync #(
   parameter int W      = 4,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < STAGES; i++) chain[i] <= '0;
      end else begin
         chain[0] <= d;
         for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/xfifo_mem.sv
module xfifo_mem #(
   parameter int DATA_W = 36,
   parameter int ADDR_W = 4
) (
   input  logic              wclk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] cells [DEPTH];

   always_ff @(posedge wclk) begin
      if (we) cells[waddr] <= wdata;
   end

   assign rdata = cells[raddr];
endmodule

// File: rtl/xfifo_wr_ctl.sv
module xfifo_wr_ctl
   import xfifo_pkg::*;
#(
   parameter int ADDR_W    = 4,
   parameter int AF_OFFSET = 2,
   parameter bit ALMOST_EN = 1'b1,
   localparam int PW       = ADDR_W + 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [PW-1:0]     rgray_sync,
   output logic              in_ready,
   output logic              almost_full,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_waddr,
   output logic [PW-1:0]     wgray
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [PW-1:0] wbin, wbin_nxt, rbin_seen, fill_nxt;

   assign mem_we    = wr_en & in_ready;
   assign mem_waddr = wbin[ADDR_W-1:0];
   assign wbin_nxt  = wbin + PW'(mem_we);
   assign rbin_seen = PW'(gray_to_bin(32'(rgray_sync)));
   assign fill_nxt  = wbin_nxt - rbin_seen;

   always_ff @(posedge clk) begin
      if (rst) begin
         wbin     <= '0;
         wgray    <= '0;
         in_ready <= 1'b1;
      end else begin
         wbin     <= wbin_nxt;
         wgray    <= PW'(bin_to_gray(32'(wbin_nxt)));
         in_ready <= (fill_nxt != PW'(DEPTH));
      end
   end

   generate
      if (ALMOST_EN) begin : g_af
         always_ff @(posedge clk) begin
            if (rst) almost_full <= 1'b0;
            else     almost_full <= (fill_nxt >= PW'(DEPTH - AF_OFFSET));
         end
      end else begin : g_no_af
         assign almost_full = 1'b0;
      end
   endgenerate

   // R8
   no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
      (wbin - rbin_seen) <= PW'(DEPTH));

   // R5
   ignored_write_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_en && !in_ready) |=> $stable(wbin));
endmodule

// File: rtl/xfifo_rd_ctl.sv
module xfifo_rd_ctl
   import xfifo_pkg::*;
#(
   parameter int DATA_W    = 36,
   parameter int ADDR_W    = 4,
   parameter int AE_OFFSET = 2,
   parameter bit ALMOST_EN = 1'b1,
   localparam int PW       = ADDR_W + 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              rd_en,
   input  logic [PW-1:0]     wgray_sync,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [ADDR_W-1:0] mem_raddr,
   output logic [PW-1:0]     rgray,
   output logic [DATA_W-1:0] rd_data,
   output logic              out_ready,
   output logic              almost_empty
);
   localparam int DEPTH = 1 << ADDR_W;
   localparam int CW    = PW + 1;

   logic [PW-1:0] rbin, rbin_nxt, wbin_seen;
   logic          mem_empty, load, or_nxt;
   logic [CW-1:0] words_nxt;

   assign wbin_seen = PW'(gray_to_bin(32'(wgray_sync)));
   assign mem_empty = (rbin == wbin_seen);
   assign mem_raddr = rbin[ADDR_W-1:0];
   assign load      = (!out_ready || rd_en) && !mem_empty;
   assign rbin_nxt  = rbin + PW'(load);
   assign or_nxt    = load ? 1'b1 : (rd_en ? 1'b0 : out_ready);
   assign words_nxt = CW'(wbin_seen - rbin_nxt) + CW'(or_nxt);

   always_ff @(posedge clk) begin
      if (rst) begin
         rbin      <= '0;
         rgray     <= '0;
         out_ready <= 1'b0;
         rd_data   <= '0;
      end else begin
         rbin      <= rbin_nxt;
         rgray     <= PW'(bin_to_gray(32'(rbin_nxt)));
         out_ready <= or_nxt;
         if (load) rd_data <= mem_rdata;
      end
   end

   generate
      if (ALMOST_EN) begin : g_ae
         always_ff @(posedge clk) begin
            if (rst) almost_empty <= 1'b1;
            else     almost_empty <= (words_nxt <= CW'(AE_OFFSET));
         end
      end else begin : g_no_ae
         assign almost_empty = 1'b0;
      end
   endgenerate

   // R4
   hold_head_chk: assert property (@(posedge clk) disable iff (rst)
      (out_ready && !rd_en) |=> (out_ready && $stable(rd_data)));

   // R7
   drain_drop_chk: assert property (@(posedge clk) disable iff (rst)
      (out_ready && rd_en && mem_empty) |=> (!out_ready && $stable(rd_data)));

   // R6
   empty_read_chk: assert property (@(posedge clk) disable iff (rst)
      (!out_ready && mem_empty) |=> (!out_ready && $stable(rd_data)));

   // R8
   no_phantom_chk: assert property (@(posedge clk) disable iff (rst)
      (wbin_seen - rbin) <= PW'(DEPTH));
endmodule

// File: rtl/xclk_fwft_fifo.sv
module xclk_fwft_fifo
   import xfifo_pkg::*;
#(
   parameter int DATA_W      = 36,
   parameter int ADDR_W      = 4,
   parameter int SYNC_STAGES = 2,
   parameter bit ALMOST_EN   = 1'b1,
   parameter int AE_OFFSET   = 2,
   parameter int AF_OFFSET   = 2
) (
   input  logic              wclk,
   input  logic              wrst,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic              in_ready,
   output logic              almost_full,
   input  logic              rclk,
   input  logic              rrst,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic              out_ready,
   output logic              almost_empty
);
   localparam int PW    = ADDR_W + 1;
   localparam int DEPTH = 1 << ADDR_W;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (ADDR_W < 2 || ADDR_W > MAX_ADDR_W) begin : g_bad_addr
         $error("ADDR_W out of supported range");
      end
      if (AE_OFFSET < 0 || AE_OFFSET >= DEPTH ||
          AF_OFFSET < 1 || AF_OFFSET >= DEPTH) begin : g_bad_off
         $error("almost offsets must lie inside the depth");
      end
   endgenerate

   logic              mem_we;
   logic [ADDR_W-1:0] waddr, raddr;
   logic [DATA_W-1:0] mem_rdata;
   logic [PW-1:0]     wgray, wgray_in_r, rgray, rgray_in_w;

   xfifo_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
      .wclk(wclk), .we(mem_we), .waddr(waddr), .wdata(wr_data),
      .raddr(raddr), .rdata(mem_rdata)
   );

   xfifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
      .clk(rclk), .rst(rrst), .d(wgray), .q(wgray_in_r)
   );

   xfifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
      .clk(wclk), .rst(wrst), .d(rgray), .q(rgray_in_w)
   );

   xfifo_wr_ctl #(.ADDR_W(ADDR_W), .AF_OFFSET(AF_OFFSET), .ALMOST_EN(ALMOST_EN)) u_wr (
      .clk(wclk), .rst(wrst), .wr_en(wr_en), .rgray_sync(rgray_in_w),
      .in_ready(in_ready), .almost_full(almost_full),
      .mem_we(mem_we), .mem_waddr(waddr), .wgray(wgray)
   );

   xfifo_rd_ctl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .AE_OFFSET(AE_OFFSET),
                  .ALMOST_EN(ALMOST_EN)) u_rd (
      .clk(rclk), .rst(rrst), .rd_en(rd_en), .wgray_sync(wgray_in_r),
      .mem_rdata(mem_rdata), .mem_raddr(raddr), .rgray(rgray),
      .rd_data(rd_data), .out_ready(out_ready), .almost_empty(almost_empty)
   );
endmodule

// File: tb/xclk_fwft_fifo_test.sv
`timescale 1ns/1ps
module xclk_fwft_fifo_test;
   localparam int DW    = 36;
   localparam int AW    = 3;
   localparam int DEPTH = 1 << AW;
   localparam int SYNC  = 2;
   localparam int AEO   = 2;
   localparam int AFO   = 2;

   logic wclk = 1'b0, rclk = 1'b0;
   logic wrst = 1'b1, rrst = 1'b1;
   logic wr_en = 1'b0, rd_en = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic [DW-1:0] rd_data;
   logic in_ready, almost_full, out_ready, almost_empty;

   int checks = 0, errors = 0;
   int wr_idx = 0, rd_idx = 0;

   always #2.5 wclk = ~wclk;
   always #3.5 rclk = ~rclk;

   xclk_fwft_fifo #(.DATA_W(DW), .ADDR_W(AW), .SYNC_STAGES(SYNC), .ALMOST_EN(1'b1),
                    .AE_OFFSET(AEO), .AF_OFFSET(AFO)) uut (
      .wclk(wclk), .wrst(wrst), .wr_en(wr_en), .wr_data(wr_data),
      .in_ready(in_ready), .almost_full(almost_full),
      .rclk(rclk), .rrst(rrst), .rd_en(rd_en), .rd_data(rd_data),
      .out_ready(out_ready), .almost_empty(almost_empty)
   );

   function automatic logic [DW-1:0] pat(int i);
      return (36'(i) * 36'd40503) ^ {12'(i), 24'h5a5a5a};
   endfunction

   task automatic chk(bit ok, string req, logic [DW-1:0] act, logic [DW-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic push_words(int n, int on, int per);
      int k = 0;
      int target = wr_idx + n;
      bit acc;
      while (wr_idx < target) begin
         @(negedge wclk);
         wr_en   = ((k % per) < on);
         wr_data = pat(wr_idx);
         acc     = wr_en && in_ready;
         k++;
         @(posedge wclk);
         if (acc) wr_idx++;
      end
      @(negedge wclk) wr_en = 1'b0;
   endtask

   task automatic pop_words(int n, int on, int per);
      int k = 0;
      int target = rd_idx + n;
      bit take;
      while (rd_idx < target) begin
         @(negedge rclk);
         rd_en = ((k % per) < on);
         take  = rd_en && out_ready;
         k++;
         if (take) chk(rd_data == pat(rd_idx), "R2 order", rd_data, pat(rd_idx));
         @(posedge rclk);
         if (take) rd_idx++;
      end
      @(negedge rclk) rd_en = 1'b0;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge wclk);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : main
      int accepted, refused, lat;
      logic [DW-1:0] held;
      bit stable_ok;

      repeat (4) @(posedge rclk);
      // R1 reset values while reset is held
      @(negedge wclk);
      chk(in_ready == 1'b1 && almost_full == 1'b0, "R1 wr reset",
          {in_ready, almost_full}, 2'b10);
      @(negedge rclk);
      chk(out_ready == 1'b0 && almost_empty == 1'b1, "R1 rd reset",
          {out_ready, almost_empty}, 2'b01);
      @(negedge wclk) wrst = 1'b0;
      @(negedge rclk) rrst = 1'b0;
      @(negedge wclk);
      chk(in_ready == 1'b1 && almost_full == 1'b0, "R1 wr after release",
          {in_ready, almost_full}, 2'b10);
      @(negedge rclk);
      chk(out_ready == 1'b0 && almost_empty == 1'b1, "R1 rd after release",
          {out_ready, almost_empty}, 2'b01);

      // R5 / R2 capacity: hammer writes with the reader idle
      accepted = 0; refused = 0;
      for (int c = 0; c < 80; c++) begin
         @(negedge wclk);
         wr_en   = 1'b1;
         wr_data = pat(wr_idx);
         if (in_ready) begin
            @(posedge wclk);
            wr_idx++; accepted++;
         end else begin
            refused++;
            @(posedge wclk);
         end
      end
      @(negedge wclk) wr_en = 1'b0;
      chk(accepted == DEPTH + 1, "R2 capacity", 36'(accepted), 36'(DEPTH + 1));
      chk(refused > 0, "R5 refused writes seen", 36'(refused), 36'd1);
      // R9 full threshold reached on the write side
      chk(almost_full == 1'b1, "R9 almost_full high", 36'(almost_full), 36'd1);
      @(negedge rclk);
      // R10 nine words visible, above threshold
      chk(almost_empty == 1'b0, "R10 almost_empty low", 36'(almost_empty), 36'd0);

      // R5 refused writes did not overwrite: drain and compare every word
      pop_words(DEPTH + 1, 1, 1);
      repeat (SYNC + 4) @(negedge rclk);
      // R7 valid drops, last word held
      chk(out_ready == 1'b0, "R7 out_ready low after drain", 36'(out_ready), 36'd0);
      chk(rd_data == pat(rd_idx - 1), "R7 last word held", rd_data, pat(rd_idx - 1));
      chk(almost_empty == 1'b1, "R10 almost_empty after drain", 36'(almost_empty), 36'd1);
      repeat (SYNC + 6) @(negedge wclk);
      chk(almost_full == 1'b0 && in_ready == 1'b1, "R9 almost_full clear",
          {almost_full, in_ready}, 2'b01);

      // R6 reads into an empty block
      held = rd_data;
      for (int c = 0; c < 6; c++) begin
         @(negedge rclk) rd_en = 1'b1;
      end
      @(negedge rclk) rd_en = 1'b0;
      chk(out_ready == 1'b0 && rd_data == held, "R6 empty reads ignored", rd_data, held);

      // R3 single word falls through on its own
      @(negedge wclk);
      wr_en = 1'b1; wr_data = pat(wr_idx);
      @(posedge wclk);
      wr_idx++;
      @(negedge wclk) wr_en = 1'b0;
      lat = 0;
      while (!out_ready && lat < 20) begin
         @(negedge rclk);
         lat++;
      end
      chk(lat <= SYNC + 4, "R3 fall-through latency", 36'(lat), 36'(SYNC + 4));
      chk(rd_data == pat(rd_idx), "R3 fall-through data", rd_data, pat(rd_idx));
      chk(almost_empty == 1'b1, "R10 one word is almost empty", 36'(almost_empty), 36'd1);

      // R4 hold with read enable low
      held = rd_data;
      stable_ok = 1'b1;
      for (int c = 0; c < 10; c++) begin
         @(negedge rclk);
         if (!out_ready || rd_data != held) stable_ok = 1'b0;
      end
      chk(stable_ok, "R4 head held", rd_data, held);
      pop_words(1, 1, 1);

      // R2 duty-cycle sweep
      for (int wp = 1; wp <= 3; wp++) begin
         for (int rp = 1; rp <= 3; rp++) begin
            fork
               push_words(40, 1, wp);
               pop_words(40, 1, rp);
            join
         end
      end
      chk(wr_idx == rd_idx, "R2 all words delivered", 36'(rd_idx), 36'(wr_idx));
      repeat (SYNC + 4) @(negedge rclk);
      chk(out_ready == 1'b0, "R7 empty after sweep", 36'(out_ready), 36'd0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule